// File: doc/BRIEF.md
# Normalization Exponent Counter

This block measures how far a signed fixed-point value can be shifted left before its sign would change. The result is a signed count of redundant sign bits that a downstream shifter uses to normalize the value. It works in one of two widths, chosen for each beat. In one mode it takes a 32-bit register-pair value. In the other it takes a 40-bit accumulator value whose eight guard bits let the count go negative.

For a negative operand, the operand is first inverted. The block then finds the most significant 1 inside a fixed search window and converts its position into a count. An operand with no 1 inside the window gives the fixed count 16. The search is a single combinational priority encoder feeding one output register.

Both edges are valid/ready streams. An input beat is taken when `in_valid` and `in_ready` are both high. A result is held on `out_count` with `out_valid` high until `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. With `out_ready` tied high, the block therefore takes one beat per cycle and answers in the following cycle.

Top module: `exp_norm_count`

## Requirements
- R1: After reset, `out_valid` is low and stays low until a beat has been accepted.
- R2: When `in_mode` is 0 (32-bit mode), a non-negative `in_pair` gives a count of 30 minus the index of its highest set bit among bits 30 down to 15.
- R3: In 32-bit mode, an `in_pair` with bit 31 set is bitwise inverted first, and then the rule of R2 applies.
- R4: When `in_mode` is 1 (40-bit mode), bit 39 of `in_acc` is the sign. A negative value is inverted first. The count is 30 minus the index of the highest set bit among bits 38 down to 15, so it ranges from -8 to 15.
- R5: In either mode, if no set bit lies inside the search window, the count is 16.
- R6: `out_count` is a 16-bit two's-complement value. Negative counts appear sign-extended, for example -8 is 16'hFFF8.
- R7: A beat accepted at a clock edge presents its count with `out_valid` high right after that edge. With `out_ready` held high, a new beat is taken every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_count` does not change.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A beat offered while `in_ready` is low is not taken and does not change the output.
- R10: Only the operand selected by `in_mode` affects the count; the other operand input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_mode | input | 1 | 0 = 32-bit pair operand, 1 = 40-bit accumulator operand |
| in_pair | input | 32 | 32-bit signed operand |
| in_acc | input | 40 | 40-bit signed operand |
| out_valid | output | 1 | Result held on out_count |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_count | output | 16 | Signed normalization count |

## Verification
The bench probes the window edges in both modes. These are a set bit at the top of the window (giving 0 and -8), a set bit at the bottom (giving 15), and a value whose only set bits lie just below the window (giving 16). A design whose window is off by one would return 16 where 15 is expected, or a negative count in 32-bit mode. The bench also drives all-ones and minimum negative values, which catch a design that inverts on the wrong sign bit or forgets to invert. It drives random back-pressure with beats offered while the output is stalled; a design that overwrote a held result or dropped a beat would diverge from the model on the next cycle. It also places garbage on the unselected operand, which exposes a design that lets the wrong mode's operand leak into the count.

// File: rtl/exp_norm_pkg.sv
package exp_norm_pkg;

  typedef enum logic {
    MODE_PAIR = 1'b0,
    MODE_ACC  = 1'b1
  } exp_mode_e;

endpackage

// File: rtl/exp_sign_fold.sv
// Folds a signed value onto its magnitude pattern: a negative value is
// inverted, so the leading 1 of the result marks the first non-sign bit.
module exp_sign_fold #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output logic [W-2:0] folded
);
  always_comb begin
    folded = val[W-2:0] ^ {(W-1){val[W-1]}};
  end
endmodule

// File: rtl/exp_lead_enc.sv
// Leading-one priority encoder: lead is the number of zeros above the most
// significant set bit, or N when the vector is all zero.
module exp_lead_enc #(
  parameter int N  = 31,
  localparam int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] lead
);
  always_comb begin
    lead = IW'(N);
    for (int i = 0; i < N; i++) begin
      if (vec[i]) lead = IW'(N - 1 - i);
    end
  end
endmodule

// File: rtl/exp_out_stage.sv
// One-entry valid/ready output register.
module exp_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) dat_q <= up_data;
    end
  end

  // R8
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  // R7
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> dn_valid);

  // R9
  not_ready_means_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ready |-> (dn_valid && !dn_ready));

  // R1
  valid_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_valid) |-> $past(up_valid));
endmodule

// File: rtl/exp_norm_count.sv
module exp_norm_count
  import exp_norm_pkg::*;
#(
  parameter int PAIR_W   = 32,
  parameter int ACC_W    = 40,
  parameter int PAIR_WIN = 16,
  parameter int ACC_WIN  = 24,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_mode,
  input  logic [PAIR_W-1:0] in_pair,
  input  logic [ACC_W-1:0] in_acc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CNT_W-1:0] out_count
);
  localparam int GUARD    = ACC_W - PAIR_W;
  localparam int NONE_CNT = PAIR_WIN;
  localparam int PIW      = $clog2(PAIR_W);
  localparam int AIW      = $clog2(ACC_W);

  exp_mode_e mode;
  assign mode = exp_mode_e'(in_mode);

  logic [PAIR_W-2:0] pair_fold;
  logic [ACC_W-2:0]  acc_fold;
  logic [PIW-1:0]    pair_lead;
  logic [AIW-1:0]    acc_lead;
  logic [CNT_W-1:0]  pair_cnt, acc_cnt, sel_cnt;

  exp_sign_fold #(.W(PAIR_W)) u_fold_pair (.val(in_pair), .folded(pair_fold));
  exp_sign_fold #(.W(ACC_W))  u_fold_acc  (.val(in_acc),  .folded(acc_fold));

  exp_lead_enc #(.N(PAIR_W - 1)) u_enc_pair (.vec(pair_fold), .lead(pair_lead));
  exp_lead_enc #(.N(ACC_W - 1))  u_enc_acc  (.vec(acc_fold),  .lead(acc_lead));

  always_comb begin
    int t;
    if (int'(pair_lead) < PAIR_WIN) t = int'(pair_lead);
    else                            t = NONE_CNT;
    pair_cnt = CNT_W'(t);
  end

  always_comb begin
    int t;
    if (int'(acc_lead) < ACC_WIN) t = int'(acc_lead) - GUARD;
    else                          t = NONE_CNT;
    acc_cnt = CNT_W'(t);
  end

  always_comb begin
    sel_cnt = (mode == MODE_ACC) ? acc_cnt : pair_cnt;
  end

  exp_out_stage #(.DW(CNT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (sel_cnt),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_count)
  );

  // R4 R5 R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_count) >= -GUARD && $signed(out_count) <= NONE_CNT));

  // R2
  pair_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == MODE_PAIR) |=> ($signed(out_count) >= 0));

  // R5
  acc_zero_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == MODE_ACC && in_acc == '0) |=> (out_count == CNT_W'(NONE_CNT)));
endmodule

// File: tb/sim_exp_norm_count.sv
module sim_exp_norm_count;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_mode = 1'b0;
  logic [31:0] in_pair = '0;
  logic [39:0] in_acc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_count;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  exp_norm_count u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_pair(in_pair), .in_acc(in_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_count(out_count)
  );

  function automatic int ref_count(bit mode, logic [31:0] p, logic [39:0] a);
    longint t;
    if (!mode) begin
      t = longint'(p);
      if (p[31]) t = (~t) & 64'hFFFF_FFFF;
      for (int i = 1; i <= 16; i++) if (t[31-i]) return i - 1;
    end else begin
      t = longint'(a);
      if (a[39]) t = (~t) & 64'hFF_FFFF_FFFF;
      for (int i = 1; i <= 24; i++) if (t[39-i]) return i - 9;
    end
    return 16;
  endfunction

  // behavioural model of the output register
  bit ev = 1'b0;
  int ec = 0;
  always @(posedge clk) begin
    if (!rst_n) ev = 1'b0;
    else if (!ev || out_ready) begin
      ev = in_valid;
      if (in_valid) ec = ref_count(in_mode, in_pair, in_acc);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== ev) begin
        errors++;
        $display("FAIL %s/R7 out_valid: actual %0b expected %0b", (rst_n ? cur_req : "R1"), out_valid, ev);
      end
      checks++;
      if (in_ready !== (!ev || out_ready)) begin
        errors++;
        $display("FAIL R9 in_ready: actual %0b expected %0b", in_ready, (!ev || out_ready));
      end
      if (ev) begin
        checks++;
        if ($signed(out_count) != ec || $isunknown(out_count)) begin
          errors++;
          $display("FAIL %s/R6 out_count: actual %0d (%h) expected %0d", cur_req,
                   $signed(out_count), out_count, ec);
        end
      end
    end
  end

  task automatic send(bit m, logic [31:0] p, logic [39:0] a, string req);
    @(negedge clk); #1;
    cur_req = req;
    in_valid = 1'b1; in_mode = m; in_pair = p; in_acc = a;
    @(negedge clk); #1;
    in_valid = 1'b0; in_pair = $urandom; in_acc = {$urandom, $urandom} ;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    // R2 non-negative pair values
    send(0, 32'h4000_0000, 40'h0, "R2");
    send(0, 32'h0000_8000, 40'h0, "R2");
    send(0, 32'h0001_0000, 40'h0, "R2");
    send(0, 32'h1234_5678, 40'h0, "R2");
    // R3 negative pair values
    send(0, 32'h8000_0000, 40'h0, "R3");
    send(0, 32'hFFFF_0000, 40'h0, "R3");
    send(0, 32'hC000_0000, 40'h0, "R3");
    // R4 accumulator values
    send(1, 32'h0, 40'h40_0000_0000, "R4");
    send(1, 32'h0, 40'h00_0000_8000, "R4");
    send(1, 32'h0, 40'hFF_8000_0000, "R4");
    send(1, 32'h0, 40'h80_0000_0000, "R4");
    send(1, 32'h0, 40'h01_0000_0000, "R4");
    // R5 nothing in window
    send(0, 32'h0000_7FFF, 40'h0, "R5");
    send(0, 32'hFFFF_FFFF, 40'h0, "R5");
    send(1, 32'h0, 40'h00_0000_7FFF, "R5");
    send(1, 32'h0, 40'hFF_FFFF_FFFF, "R5");
    // R10 unselected operand ignored
    send(0, 32'h0000_0001, 40'h40_0000_0000, "R10");
    send(1, 32'h4000_0000, 40'h00_0000_0001, "R10");
    // R7 R8 R9 streaming with random back-pressure
    cur_req = "R8";
    for (int n = 0; n < 600; n++) begin
      @(negedge clk); #1;
      in_valid  = ($urandom % 4) != 0;
      out_ready = ($urandom % 3) != 0;
      in_mode   = $urandom % 2;
      in_pair   = $urandom >> ($urandom % 32);
      in_acc    = {$urandom, $urandom} >> ($urandom % 40);
      if ($urandom % 2) begin
        in_pair = ~in_pair;
        in_acc  = ~in_acc;
      end
    end
    @(negedge clk); #1;
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule